// File: doc/BRIEF.md
# Reloadable Periodic Interval Timer

This block produces a steady periodic interrupt for a processor subsystem. A free-running prescaler divides the system clock down to one-millisecond steps. A millisecond counter then compares the elapsed steps against a programmed reload value. When the counter reaches that value, the interrupt line goes high and a new period starts at once. The period is therefore (reload + 1) milliseconds, which gives a tick rate of 1000 / (reload + 1) Hz.

Software programs the period over a simple register port, with one-cycle write and read strobes and an address. A write to the reload offset does three things: it stores the new value, it drops the interrupt, and it restarts the period from zero. A read of the count offset always returns zero, and as a side effect it acknowledges the interrupt. A separate debug offset lets the reload value be read back. It also lets the reload value be changed without disturbing the current interrupt or the current period.

Top module: `ptick_timer`

## Requirements
- R1: While reset is held, and immediately after it, `irqOut` is low and the stored reload value is 0.
- R2: After a write of value V to offset 0x228 in clock edge E, `irqOut` rises exactly at edge E + (V+1)·CLK_PER_MS. It stays high if unacknowledged, and each later period is again (V+1)·CLK_PER_MS cycles long.
- R3: A write to offset 0x228 drives `irqOut` low on the following cycle and restarts the period from zero. This holds even when an expiry falls in the same cycle.
- R4: A read of offset 0x230 returns 0 on `regRdData` one cycle later and drives `irqOut` low on the following cycle.
- R5: When a read of offset 0x230 and an expiry happen in the same cycle, `irqOut` is high on the following cycle.
- R6: Offset 0x240 reads back the 32-bit reload value one cycle after the read. A write there updates the reload value without lowering `irqOut` and without restarting the period. The current period then ends at the first millisecond boundary where the elapsed millisecond count has reached the new value.
- R7: Reads of any other offset return 0 and leave `irqOut` unchanged. Writes to any other offset change neither `irqOut`, the period phase, nor the reload value.
- R8: With the reset reload value of 0, `irqOut` first rises CLK_PER_MS edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe, one cycle per access |
| regRdEn | input | 1 | Read strobe, one cycle per access |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWrData | input | DATA_W | Write data |
| regRdData | output | DATA_W | Read data, valid the cycle after `regRdEn` |
| irqOut | output | 1 | Periodic interrupt, level high until acknowledged |

## Verification
A wrong prescaler or millisecond count shows at the ports only as a shifted rising edge of `irqOut`. For that reason, every rise is checked at its exact cycle: one cycle before the edge the line must be low, and at the edge it must be high. A single-cycle phase error is then caught within one period. A reload register that is corrupted or wrongly restarted shows both in the debug readback, on the next cycle, and in the length of the following period. Errors in the priority between acknowledge, reload write and expiry show one cycle after the colliding access. The bench therefore times accesses to land exactly on expiry edges.

// File: rtl/ptick_pkg.sv
package ptick_pkg;
  // register offsets (bytes)
  localparam int unsigned RELOAD_OFS = 'h228;
  localparam int unsigned COUNT_OFS  = 'h230;
  localparam int unsigned DEBUG_OFS  = 'h240;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;     // clear prescaler and ms counter
    logic loadReload;  // capture write data as reload, with restart
    logic loadDebug;   // capture write data as reload, phase kept
  } tickStrobes_t;
endpackage

// File: rtl/ptick_datapath.sv
module ptick_datapath
  import ptick_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CLK_PER_MS = 125000
) (
  input  logic              clk,
  input  logic              rstN,
  input  tickStrobes_t      strobes,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] reloadVal,
  output logic              expire
);
  localparam int PRE_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_MS - 1);

  logic [PRE_W-1:0]  preCnt;
  logic [DATA_W-1:0] msCnt;
  logic [DATA_W-1:0] reloadQ;
  logic              msTick;
  logic              hit;

  assign msTick    = (preCnt == PRE_LAST);
  // >= lets a debug write below the elapsed count end the period promptly
  assign hit       = msTick && (msCnt >= reloadQ);
  assign expire    = hit && !strobes.restart;
  assign reloadVal = reloadQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (strobes.restart) begin
      preCnt <= '0;
      msCnt  <= '0;
    end else if (msTick) begin
      preCnt <= '0;
      msCnt  <= hit ? '0 : msCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (strobes.loadReload || strobes.loadDebug) begin
      reloadQ <= wrData;
    end
  end
endmodule

// File: rtl/ptick_ctrl.sv
module ptick_ctrl
  import ptick_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] reloadVal,
  input  logic              expire,
  output tickStrobes_t      strobes,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  logic wrReload, wrDebug, rdCount, rdDebug;

  assign wrReload = regWrEn && (regAddr == ADDR_W'(RELOAD_OFS));
  assign wrDebug  = regWrEn && (regAddr == ADDR_W'(DEBUG_OFS));
  assign rdCount  = regRdEn && (regAddr == ADDR_W'(COUNT_OFS));
  assign rdDebug  = regRdEn && (regAddr == ADDR_W'(DEBUG_OFS));

  always_comb begin
    strobes            = '0;
    strobes.restart    = wrReload;
    strobes.loadReload = wrReload;
    strobes.loadDebug  = wrDebug;
  end

  // priority: reload write, then expiry, then acknowledge read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut <= 1'b0;
    end else if (wrReload) begin
      irqOut <= 1'b0;
    end else if (expire) begin
      irqOut <= 1'b1;
    end else if (rdCount) begin
      irqOut <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regRdData <= '0;
    end else if (rdDebug) begin
      regRdData <= reloadVal;
    end else begin
      regRdData <= '0;
    end
  end
endmodule

// File: rtl/ptick_timer.sv
module ptick_timer
  import ptick_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int CLK_PER_MS = 125000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  tickStrobes_t      strobes;
  logic [DATA_W-1:0] reloadVal;
  logic              expirePulse;

  ptick_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regAddr   (regAddr),
    .reloadVal (reloadVal),
    .expire    (expirePulse),
    .strobes   (strobes),
    .regRdData (regRdData),
    .irqOut    (irqOut)
  );

  ptick_datapath #(.DATA_W(DATA_W), .CLK_PER_MS(CLK_PER_MS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (regWrData),
    .reloadVal (reloadVal),
    .expire    (expirePulse)
  );
endmodule

// File: rtl/ptick_timer_chk.sv
module ptick_timer_chk
  import ptick_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic              regRdEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              irqOut,
  input logic              expirePulse,
  input logic [DATA_W-1:0] reloadVal
);
  logic wrRel, rdCnt, rdDbg, rdOther;
  assign wrRel   = regWrEn && (regAddr == ADDR_W'(RELOAD_OFS));
  assign rdCnt   = regRdEn && (regAddr == ADDR_W'(COUNT_OFS));
  assign rdDbg   = regRdEn && (regAddr == ADDR_W'(DEBUG_OFS));
  assign rdOther = regRdEn && !rdCnt && !rdDbg;

  // R2
  rise_needs_expiry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(expirePulse));
  // R3
  reload_write_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrRel |=> !irqOut);
  // R4
  count_read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdCnt && !expirePulse && !wrRel |=> !irqOut);
  // R4
  count_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdCnt |=> regRdData == '0);
  // R5
  expiry_beats_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse && !wrRel |=> irqOut);
  // R6
  debug_readback_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdDbg |=> regRdData == $past(reloadVal));
  // R7
  other_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdOther |=> regRdData == '0);
endmodule

bind ptick_timer ptick_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regRdEn     (regRdEn),
  .regAddr     (regAddr),
  .regRdData   (regRdData),
  .irqOut      (irqOut),
  .expirePulse (expirePulse),
  .reloadVal   (reloadVal)
);

// File: tb/ptick_timer_tb.sv
module ptick_timer_tb;
  localparam int CPM    = 4;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_RELOAD = 12'h228;
  localparam logic [ADDR_W-1:0] A_COUNT  = 12'h230;
  localparam logic [ADDR_W-1:0] A_DEBUG  = 12'h240;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regWrEn = 1'b0;
  logic              regRdEn = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic              irqOut;

  always #4 clk = ~clk; // 125 MHz

  ptick_timer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PER_MS(CPM)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  typedef struct { string tag; logic [DATA_W-1:0] val; } rdItem_t;
  rdItem_t expQ[$];
  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;

  task automatic chk(string tag, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  // drivers: called at a negedge, access sampled at the next posedge
  task automatic doWrite(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] e, string tag);
    rdItem_t it;
    it.tag = tag; it.val = e;
    expQ.push_back(it);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // monitor: compares read data the cycle after each read strobe
  initial begin
    forever begin
      logic wasRd;
      @(posedge clk);
      wasRd = regRdEn;
      @(negedge clk);
      if (wasRd) begin
        if (expQ.size() == 0) begin
          total++; bad++;
          $display("FAIL scoreboard: actual=read expected=none");
        end else begin
          rdItem_t it;
          it = expQ.pop_front();
          chk(it.tag, regRdData, it.val);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p;
    waitN(3);
    chk("R1 irq in reset", irqOut, 0);
    rstN = 1'b1;
    waitN(CPM - 1);
    chk("R8 before first tick", irqOut, 0);
    waitN(1);
    chk("R8 first tick", irqOut, 1);

    // reload 2 -> period 3 ms
    p = 3 * CPM;
    doWrite(A_RELOAD, 2);
    chk("R3 write clears", irqOut, 0);
    waitN(p - 1);
    chk("R2 one cycle early", irqOut, 0);
    waitN(1);
    chk("R2 rise on time", irqOut, 1);
    waitN(p);
    chk("R2 stays high unacked", irqOut, 1);
    doRead(A_COUNT, 0, "R4 count reads zero");
    chk("R4 ack clears", irqOut, 0);
    waitN(p - 2);
    chk("R2 next period early", irqOut, 0);
    waitN(1);
    chk("R2 next period rise", irqOut, 1);

    // ack colliding with expiry
    waitN(p - 1);
    doRead(A_COUNT, 0, "R5 read data");
    chk("R5 expiry wins", irqOut, 1);

    // reload write colliding with expiry; reload 1 -> 2 ms
    waitN(p - 1);
    doWrite(A_RELOAD, 1);
    chk("R3 write beats expiry", irqOut, 0);
    waitN(2 * CPM - 1);
    chk("R3 restart early", irqOut, 0);
    waitN(1);
    chk("R3 restart rise", irqOut, 1);

    // debug access
    doRead(A_DEBUG, 1, "R6 debug readback");
    doWrite(A_DEBUG, 5);
    chk("R6 debug write keeps irq", irqOut, 1);
    doRead(A_COUNT, 0, "R4 count reads zero");
    chk("R4 ack clears again", irqOut, 0);
    waitN(20);
    chk("R6 no restart early", irqOut, 0);
    waitN(1);
    chk("R6 no restart rise", irqOut, 1);

    // unmapped accesses
    doRead(12'h100, 0, "R7 unmapped read zero");
    chk("R7 unmapped read keeps irq", irqOut, 1);
    doWrite(12'h22C, 7);
    chk("R7 unmapped write keeps irq", irqOut, 1);
    doRead(A_COUNT, 0, "R4 count reads zero");
    waitN(20);
    chk("R7 phase kept early", irqOut, 0);
    waitN(1);
    chk("R7 phase kept rise", irqOut, 1);
    doRead(A_DEBUG, 5, "R7 reload unchanged");
    waitN(2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule